// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block sets the time grid of one bit on a CAN bus. A prescaler divides the system clock into time quanta. A small state machine then walks each bit through three phases: a one-quantum synchronization phase, a first timing segment that covers propagation and the first phase buffer, and a second timing segment that holds the second phase buffer. The bus level is captured at the boundary between the two timing segments and is reported with a one-clock sample strobe. A transmit-point strobe marks the start of every bit, so that a frame engine can present its next bit there.

The unit checks the received line once per quantum and reacts only to recessive-to-dominant transitions. While the frame logic reports the bus idle, such a transition restarts the bit at once (hard synchronization). Inside a frame, a transition that arrives late stretches the first segment, and one that arrives early cuts the second segment or starts a new bit at once. Each correction is limited to the jump width. The sample point therefore moves with the measured phase error and does not sit at a fixed count. Frame decoding, stuffing and error handling belong to other blocks.

The state machine has three states. `ST_SYNC` is the synchronization quantum. `ST_SEG1` is the first timing segment. `ST_SEG2` is the second timing segment. Counted transitions run SYNC to SEG1, SEG1 to SEG2 (the sample point), and SEG2 to SYNC (the transmit point). Edge-driven transitions run from any state to SYNC on a hard synchronization, and from SEG1 or SEG2 to SYNC on an early edge that is within the jump width.

Top module: `can_bit_timer`

## Requirements
- R1: While reset is held, and straight after it, `tx_point` and `sample_point` are 0 and `sample_bit` is 1 (recessive).
- R2: One time quantum lasts `quanta_div_m1`+1 system clocks (1 to 64).
- R3: With no edges, a bit lasts 1 + (`seg1_m1`+1) + (`seg2_m1`+1) quanta. `tx_point` pulses for one clock each time the SYNC phase is entered. `sample_point` pulses for one clock when SEG1 gives way to SEG2, 1+(`seg1_m1`+1) quanta after the transmit point.
- R4: `sample_bit` takes the level of `rx_in` (1 = recessive, 0 = dominant) seen at the sample point and holds it until the next sample point.
- R5: An edge is a change of `rx_in` from 1 to 0 between two consecutive quantum ticks. Rising changes have no effect on timing.
- R6: When `bus_idle` is 1, an edge makes the next quantum a SYNC quantum, whatever the current phase.
- R7: An edge that makes the next quantum the n-th quantum of SEG1 (late by n) lengthens SEG1 of the current bit by min(n, jump width).
- R8: An edge that makes the next quantum fall into SEG2 with k quanta of SEG2 still ahead (early by k), where k ≤ jump width, makes that next quantum a SYNC quantum.
- R9: An early edge with k > jump width shortens SEG2 of the current bit by exactly the jump width.
- R10: Only the first edge in a bit causes a resynchronization. A bit started by an edge-driven SYNC admits none.
- R11: The jump width used is min(`jump_m1`+1, `seg2_m1`+1).
- R12: An edge whose next quantum is the nominal SYNC quantum (zero phase error) changes no timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| quanta_div_m1 | input | 6 | Quantum length in clocks, minus one |
| seg1_m1 | input | 4 | SEG1 length in quanta minus one (1..15 for 2..16) |
| seg2_m1 | input | 3 | SEG2 length in quanta minus one (0..7 for 1..8) |
| jump_m1 | input | 2 | Jump width in quanta minus one (0..3 for 1..4) |
| bus_idle | input | 1 | Frame logic reports idle bus; enables hard synchronization |
| rx_in | input | 1 | Received bus level, 0 dominant |
| tx_point | output | 1 | One-clock strobe at the start of each bit |
| sample_point | output | 1 | One-clock strobe at the sample point |
| sample_bit | output | 1 | Bus level captured at the latest sample point |

## Verification
The bench places falling edges at chosen quanta around the sample point and measures both strobes in clocks from the previous transmit point. A late edge that ignored the jump width would move the sample point too far. An early edge handled as late, or cut by the wrong amount, would give a bit of the wrong length. A second edge in one bit that was allowed to act would move the sample point a second time. Other cases checked are a jump width above the SEG2 length, a rising edge that must change nothing, an edge exactly on the nominal SYNC quantum, and a hard synchronization in mid-bit. A faulty design would show each of these as a shifted strobe or as a wrong captured level.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    typedef enum logic [1:0] {
        ST_SYNC = 2'd0,
        ST_SEG1 = 2'd1,
        ST_SEG2 = 2'd2
    } bt_state_e;

endpackage

// File: rtl/cbt_quantum_gen.sv
module cbt_quantum_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_m1,
    output logic             tq_tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tq_tick = (cnt_q >= div_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tq_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tq_tick |=> (!tq_tick || div_m1 == '0));

endmodule

// File: rtl/cbt_fall_detect.sv
module cbt_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic tq_tick,
    input  logic rx_in,
    output logic fall
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else if (tq_tick) begin
            prev_q <= rx_in;
        end
    end

    assign fall = tq_tick & prev_q & ~rx_in;

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
    parameter int DIV_W  = 6,
    parameter int SEG1_W = 4,
    parameter int SEG2_W = 3,
    parameter int JUMP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  quanta_div_m1,
    input  logic [SEG1_W-1:0] seg1_m1,
    input  logic [SEG2_W-1:0] seg2_m1,
    input  logic [JUMP_W-1:0] jump_m1,
    input  logic              bus_idle,
    input  logic              rx_in,
    output logic              tx_point,
    output logic              sample_point,
    output logic              sample_bit
);
    import cbt_pkg::*;

    localparam int CNT_W = ((SEG1_W > SEG2_W) ? SEG1_W : SEG2_W) + 2;
    localparam logic [CNT_W-1:0] ONE = 1;

    logic tq_tick;
    logic fall;

    cbt_quantum_gen #(.DIV_W(DIV_W)) u_qgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_m1  (quanta_div_m1),
        .tq_tick (tq_tick)
    );

    cbt_fall_detect u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .tq_tick (tq_tick),
        .rx_in   (rx_in),
        .fall    (fall)
    );

    bt_state_e        state_q, nom_st, nxt_st;
    logic [CNT_W-1:0] qcnt_q, nom_cnt, nxt_cnt;
    logic [CNT_W-1:0] ext_q, nxt_ext, shr_q, nxt_shr;
    logic             used_q, nxt_used;
    logic [CNT_W-1:0] len1_nom, len2_nom, jump_raw, jump_eff, len1, len2;
    logic [CNT_W-1:0] late_err, early_err, late_adj;
    logic             at_sample;

    assign len1_nom = CNT_W'(seg1_m1) + ONE;
    assign len2_nom = CNT_W'(seg2_m1) + ONE;
    assign jump_raw = CNT_W'(jump_m1) + ONE;
    assign jump_eff = (jump_raw < len2_nom) ? jump_raw : len2_nom;
    assign len1     = len1_nom + ext_q;
    assign len2     = len2_nom - shr_q;

    // counted progress through the bit
    always_comb begin
        nom_st  = state_q;
        nom_cnt = qcnt_q + ONE;
        unique case (state_q)
            ST_SYNC: begin
                nom_st  = ST_SEG1;
                nom_cnt = '0;
            end
            ST_SEG1: begin
                if (qcnt_q >= len1 - ONE) begin
                    nom_st  = ST_SEG2;
                    nom_cnt = '0;
                end
            end
            ST_SEG2: begin
                if (qcnt_q >= len2 - ONE) begin
                    nom_st  = ST_SYNC;
                    nom_cnt = '0;
                end
            end
            default: begin
                nom_st  = ST_SYNC;
                nom_cnt = '0;
            end
        endcase
    end

    assign late_err  = nom_cnt + ONE;
    assign early_err = len2 - nom_cnt;
    assign late_adj  = (late_err < jump_eff) ? late_err : jump_eff;
    assign at_sample = (state_q == ST_SEG1) && (nom_st == ST_SEG2);

    // edge-driven corrections
    always_comb begin
        nxt_st   = nom_st;
        nxt_cnt  = nom_cnt;
        nxt_ext  = ext_q;
        nxt_shr  = shr_q;
        nxt_used = used_q;
        if (nom_st == ST_SYNC) begin
            nxt_ext  = '0;
            nxt_shr  = '0;
            nxt_used = 1'b0;
        end
        if (fall && bus_idle) begin
            nxt_st   = ST_SYNC;
            nxt_cnt  = '0;
            nxt_ext  = '0;
            nxt_shr  = '0;
            nxt_used = 1'b1;
        end else if (fall && !used_q) begin
            case (nom_st)
                ST_SEG1: begin
                    nxt_ext  = ext_q + late_adj;
                    nxt_used = 1'b1;
                end
                ST_SEG2: begin
                    nxt_used = 1'b1;
                    if (early_err <= jump_eff) begin
                        nxt_st  = ST_SYNC;
                        nxt_cnt = '0;
                        nxt_ext = '0;
                        nxt_shr = '0;
                    end else begin
                        nxt_shr = shr_q + jump_eff;
                    end
                end
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SYNC;
            qcnt_q  <= '0;
            ext_q   <= '0;
            shr_q   <= '0;
            used_q  <= 1'b0;
        end else if (tq_tick) begin
            state_q <= nxt_st;
            qcnt_q  <= nxt_cnt;
            ext_q   <= nxt_ext;
            shr_q   <= nxt_shr;
            used_q  <= nxt_used;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_point     <= 1'b0;
            sample_point <= 1'b0;
            sample_bit   <= 1'b1;
        end else begin
            tx_point     <= tq_tick && (nxt_st == ST_SYNC);
            sample_point <= tq_tick && at_sample;
            if (tq_tick && at_sample) begin
                sample_bit <= rx_in;
            end
        end
    end

    // R3
    tx_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_point |-> (state_q == ST_SYNC));

    // R4
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sample_bit) |-> sample_point);

    // R6
    hard_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && bus_idle) |=> (tx_point && state_q == ST_SYNC));

    // R10
    one_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used_q |=> ((ext_q == $past(ext_q) && shr_q == $past(shr_q)) || state_q == ST_SYNC));

endmodule

// File: tb/sim_can_bit_timer.sv
module sim_can_bit_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] quanta_div_m1 = 6'd0;
    logic [3:0] seg1_m1 = 4'd5;
    logic [2:0] seg2_m1 = 3'd2;
    logic [1:0] jump_m1 = 2'd1;
    logic       bus_idle = 1'b0;
    logic       rx_in = 1'b1;
    logic       tx_point, sample_point, sample_bit;

    int n_chk = 0;
    int n_bad = 0;
    int ts, tt;

    always #5 clk = ~clk;

    can_bit_timer u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .quanta_div_m1 (quanta_div_m1),
        .seg1_m1       (seg1_m1),
        .seg2_m1       (seg2_m1),
        .jump_m1       (jump_m1),
        .bus_idle      (bus_idle),
        .rx_in         (rx_in),
        .tx_point      (tx_point),
        .sample_point  (sample_point),
        .sample_bit    (sample_bit)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sync_to_tx();
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (tx_point) return;
        end
    endtask

    // Starts on a negedge where tx_point was seen (index 0). Drives rx_in
    // low at d0, high at u1, low at d2; reports strobe positions in clocks.
    task automatic step_bit(input int d0, input int u1, input int d2,
                            output int t_s, output int t_t);
        t_s = -1;
        t_t = -1;
        for (int k = 0; k < 200 && t_t < 0; k++) begin
            if (k > 0) begin
                @(negedge clk);
                if (sample_point && t_s < 0) t_s = k;
                if (tx_point) t_t = k;
            end
            if (k == d0) rx_in = 1'b0;
            if (k == u1) rx_in = 1'b1;
            if (k == d2) rx_in = 1'b0;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 tx_point in reset", tx_point, 0);
        chk("R1 sample_point in reset", sample_point, 0);
        chk("R1 sample_bit in reset", sample_bit, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tx_point after reset", tx_point, 0);
        sync_to_tx();
    endtask

    task automatic t_nominal();
        step_bit(-1, -1, -1, ts, tt);
        chk("R3 sample offset", ts, 7);
        chk("R3 bit length", tt, 10);
        chk("R4 sampled recessive", sample_bit, 1);
    endtask

    task automatic t_zero_phase();
        step_bit(9, -1, -1, ts, tt);
        chk("R12 sample offset", ts, 7);
        chk("R12 bit length", tt, 10);
        step_bit(-1, -1, -1, ts, tt);
        chk("R12 following bit", tt, 10);
        chk("R4 sampled dominant", sample_bit, 0);
    endtask

    task automatic t_rising();
        step_bit(-1, 3, -1, ts, tt);
        chk("R5 rising edge sample offset", ts, 7);
        chk("R5 rising edge bit length", tt, 10);
        chk("R4 sampled after rise", sample_bit, 1);
    endtask

    task automatic t_late_once();
        step_bit(0, 1, 3, ts, tt);
        chk("R7 late by one sample offset", ts, 8);
        chk("R10 second edge ignored", tt, 11);
        step_bit(-1, 2, -1, ts, tt);
        chk("R7 next bit nominal", tt, 10);
    endtask

    task automatic t_late_limit();
        step_bit(3, -1, -1, ts, tt);
        chk("R7 late limited sample offset", ts, 9);
        chk("R7 late limited bit length", tt, 12);
        step_bit(-1, 2, -1, ts, tt);
    endtask

    task automatic t_early_within();
        step_bit(8, -1, -1, ts, tt);
        chk("R8 early sample offset", ts, 7);
        chk("R8 early bit length", tt, 9);
        step_bit(-1, 2, -1, ts, tt);
        chk("R8 bit after early sync", tt, 10);
    endtask

    task automatic t_early_beyond();
        step_bit(6, -1, -1, ts, tt);
        chk("R9 sample offset", ts, 7);
        chk("R9 shortened bit length", tt, 8);
        step_bit(-1, 2, -1, ts, tt);
        chk("R9 next bit restored", tt, 10);
    endtask

    task automatic t_hard_sync();
        bus_idle = 1'b1;
        step_bit(3, -1, -1, ts, tt);
        chk("R6 hard sync restarts bit", tt, 4);
        bus_idle = 1'b0;
        step_bit(-1, -1, -1, ts, tt);
        chk("R6 sample after hard sync", ts, 7);
        chk("R6 bit after hard sync", tt, 10);
        chk("R4 dominant captured", sample_bit, 0);
        step_bit(-1, 2, -1, ts, tt);
    endtask

    task automatic t_clamp();
        seg2_m1 = 3'd0;
        jump_m1 = 2'd3;
        sync_to_tx();
        step_bit(3, -1, -1, ts, tt);
        chk("R11 clamped late sample offset", ts, 8);
        chk("R11 clamped bit length", tt, 9);
        seg2_m1 = 3'd2;
        jump_m1 = 2'd1;
        sync_to_tx();
        step_bit(-1, 2, -1, ts, tt);
    endtask

    task automatic t_prescale();
        quanta_div_m1 = 6'd3;
        sync_to_tx();
        step_bit(-1, -1, -1, ts, tt);
        chk("R2 sample offset in clocks", ts, 28);
        chk("R2 bit length in clocks", tt, 40);
    endtask

    initial begin
        t_reset();
        t_nominal();
        t_zero_phase();
        t_rising();
        t_late_once();
        t_late_limit();
        t_early_within();
        t_early_beyond();
        t_hard_sync();
        t_clamp();
        t_prescale();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule